// File: doc/BRIEF.md
# Windowed Watchdog Timer

The block counts down a programmable period on a slow, free-running oscillator tick. Software proves it is alive by writing a two-word key pair to a service register. A correct pair reloads the counter from the period register. If the counter runs out, the first expiry raises either an interrupt flag or a reset request, depending on a control bit. A further expiry while that flag is still set always raises the reset request. In window mode, a key pair that completes while the counter is still at or above a window threshold is treated as a fault and raises the reset request.

Configuration is reached over a simple single-cycle register bus that carries a master identifier. A per-master permission mask, a soft lock (released by a second key pair) and a hard lock (held until reset) guard the configuration. Refused accesses return an error in the same cycle and change nothing.

Word addresses: 0 control, 1 flag, 2 period, 3 window, 4 service, 5 counter (read only). Control bits: [0] run, [1] interrupt on first expiry, [2] window mode, [3] soft lock, [4] hard lock, [15:8] permission mask for masters 0..7.

Top module: `winwdt`

## Requirements
- R1: After reset, control reads 0x0000FF00, the period register reads the reset period 0x0000FFFF, the counter reads that same value, and the interrupt and reset outputs are low.
- R2: The tick input is registered once. While run is set, each registered tick lowers the counter by one. A tick at zero is an expiry and reloads the period. Without a tick the counter holds. While run is clear, the counter follows the period register.
- R3: Writing 0x0000A602 and then 0x0000B480 to address 4 is a service and reloads the counter from the period register. Any other value in between breaks the pair.
- R4: On an expiry with the flag clear, control bit 1 = 1 sets the flag (read at address 1 bit 0, driven on the interrupt output). Control bit 1 = 0 raises the reset request.
- R5: An expiry while the flag is already set raises the reset request.
- R6: Writing 1 to bit 0 of address 1 clears the flag. A flag cleared before the next expiry lets that expiry set it again without a reset.
- R7: With control bit 2 set, a service completed while the counter is at or above the window register raises the reset request. A service while the counter is below it only reloads.
- R8: While control bit 3 (soft lock) is set, writes to addresses 0, 2 and 3 return an error and leave the registers unchanged.
- R9: Writing 0x0000C520 and then 0x0000D928 to address 4 clears the soft lock when the hard lock is clear. A broken pair does not clear it.
- R10: Control bit 4 (hard lock) stays set until reset. It refuses writes to addresses 0, 2 and 3, and the unlock pair has no effect on it.
- R11: An access by a master whose mask bit is clear returns an error and read data 0, and changes no state.
- R12: An access to an address above 5, or a write to address 5, returns an error.
- R13: Once raised, the reset request stays high until the block is reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | Slow oscillator tick (pulse or raw level, per parameter) |
| bus_valid | input | 1 | Access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_master | input | MST_W | Identifier of the requesting master |
| bus_rdata | output | 32 | Read data, same cycle, 0 on error |
| bus_err | output | 1 | Access refused, same cycle |
| wdt_irq | output | 1 | Pending first-expiry flag |
| wdt_rst_req | output | 1 | Sticky reset request |

## Verification
The hardest case to reach is a second expiry that lands on the very cycle the flag is being cleared, or a service that completes just as the counter crosses the window threshold. Both depend on the counter value being exact when the bus write arrives. The stimulus therefore uses tiny periods and drives a tick on chosen cycles, while reading the counter every cycle. This makes the counter's position at every bus write known. A behavioural model in the bench predicts the error, read data and both outputs on every clock, so an off-by-one in reload, window comparison or flag priority shows up on the first cycle it matters.

// File: rtl/winwdt_pkg.sv
package winwdt_pkg;

   localparam int unsigned A_CTRL = 0;
   localparam int unsigned A_FLAG = 1;
   localparam int unsigned A_PERIOD = 2;
   localparam int unsigned A_WINDOW = 3;
   localparam int unsigned A_SERVICE = 4;
   localparam int unsigned A_COUNT = 5;

   localparam logic [31:0] KEY_SVC_FIRST = 32'h0000_A602;
   localparam logic [31:0] KEY_SVC_SECOND = 32'h0000_B480;
   localparam logic [31:0] KEY_UNL_FIRST = 32'h0000_C520;
   localparam logic [31:0] KEY_UNL_SECOND = 32'h0000_D928;

   localparam int unsigned MASK_LSB = 8;

   typedef enum logic [1:0] {
      KS_IDLE = 2'd0,
      KS_SVC  = 2'd1,
      KS_UNL  = 2'd2
   } key_st_t;

   typedef struct packed {
      logic hlock;
      logic slock;
      logic win;
      logic irq_first;
      logic run;
   } wdt_cfg_t;

endpackage

// File: rtl/winwdt_tick.sv
module winwdt_tick #(
   parameter int unsigned TICK_MODE = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_in,
   output logic tick_o
);

   if (TICK_MODE > 1) begin : g_bad_mode
      $error("winwdt_tick: TICK_MODE must be 0 or 1");
   end

   if (TICK_MODE == 0) begin : g_pulse
      logic tick_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) tick_q <= 1'b0;
         else        tick_q <= tick_in;
      end
      assign tick_o = tick_q;
   end else begin : g_level
      logic [2:0] sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q <= '0;
         else        sync_q <= {sync_q[1:0], tick_in};
      end
      assign tick_o = sync_q[1] & ~sync_q[2];
   end

endmodule

// File: rtl/winwdt_regs.sv
module winwdt_regs
   import winwdt_pkg::*;
#(
   parameter int unsigned ADDR_W  = 4,
   parameter int unsigned CNT_W   = 32,
   parameter int unsigned MST_W   = 3,
   parameter logic [31:0] TO_RST  = 32'h0000_FFFF,
   parameter logic [31:0] WIN_RST = 32'h0,
   parameter bit          RUN_RST = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   input  logic [MST_W-1:0]  bus_master,
   input  logic [CNT_W-1:0]  cnt_i,
   input  logic              flag_i,
   output wdt_cfg_t          cfg_o,
   output logic [CNT_W-1:0]  period_o,
   output logic [CNT_W-1:0]  window_o,
   output logic              svc_o,
   output logic              flag_clr_o,
   output logic              bus_err,
   output logic [31:0]       bus_rdata
);

   localparam int unsigned NMST = 1 << MST_W;

   if (ADDR_W < 3 || ADDR_W > 16) begin : g_chk_addr
      $error("winwdt_regs: ADDR_W out of range");
   end
   if (CNT_W < 8 || CNT_W > 32) begin : g_chk_cnt
      $error("winwdt_regs: CNT_W out of range");
   end
   if (MST_W < 1 || MST_W > 4) begin : g_chk_mst
      $error("winwdt_regs: MST_W out of range");
   end

   wdt_cfg_t          cfg_q;
   logic [NMST-1:0]   mask_q;
   logic [CNT_W-1:0]  period_q;
   logic [CNT_W-1:0]  window_q;
   key_st_t           key_q;
   key_st_t           key_d;

   logic sel_ctrl, sel_flag, sel_per, sel_win, sel_svc, sel_cnt;
   logic mapped, is_cfg, allowed, locked, wr_ok, rd_ok, unl_hit;

   always_comb begin
      sel_ctrl = bus_addr == ADDR_W'(A_CTRL);
      sel_flag = bus_addr == ADDR_W'(A_FLAG);
      sel_per  = bus_addr == ADDR_W'(A_PERIOD);
      sel_win  = bus_addr == ADDR_W'(A_WINDOW);
      sel_svc  = bus_addr == ADDR_W'(A_SERVICE);
      sel_cnt  = bus_addr == ADDR_W'(A_COUNT);
      mapped   = sel_ctrl | sel_flag | sel_per | sel_win | sel_svc | sel_cnt;
      is_cfg   = sel_ctrl | sel_per | sel_win;
      allowed  = mask_q[bus_master];
      locked   = cfg_q.slock | cfg_q.hlock;
      bus_err  = bus_valid & (~allowed | ~mapped | (bus_write & sel_cnt)
                              | (bus_write & is_cfg & locked));
      wr_ok    = bus_valid & bus_write & ~bus_err;
      rd_ok    = bus_valid & ~bus_write & ~bus_err;
   end

   // key sequencer: a first key arms, anything else disarms
   always_comb begin
      if (bus_wdata == KEY_SVC_FIRST)      key_d = KS_SVC;
      else if (bus_wdata == KEY_UNL_FIRST) key_d = KS_UNL;
      else                                 key_d = KS_IDLE;
   end

   assign svc_o   = wr_ok & sel_svc & (key_q == KS_SVC) & (bus_wdata == KEY_SVC_SECOND);
   assign unl_hit = wr_ok & sel_svc & (key_q == KS_UNL) & (bus_wdata == KEY_UNL_SECOND);
   assign flag_clr_o = wr_ok & sel_flag & bus_wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 key_q <= KS_IDLE;
      else if (wr_ok && sel_svc)  key_q <= key_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= '{hlock: 1'b0, slock: 1'b0, win: 1'b0, irq_first: 1'b0, run: RUN_RST};
         mask_q <= '1;
      end else if (wr_ok && sel_ctrl) begin
         cfg_q.run       <= bus_wdata[0];
         cfg_q.irq_first <= bus_wdata[1];
         cfg_q.win       <= bus_wdata[2];
         cfg_q.slock     <= bus_wdata[3];
         cfg_q.hlock     <= bus_wdata[4];
         mask_q          <= bus_wdata[MASK_LSB +: NMST];
      end else if (unl_hit && !cfg_q.hlock) begin
         cfg_q.slock <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         period_q <= TO_RST[CNT_W-1:0];
         window_q <= WIN_RST[CNT_W-1:0];
      end else if (wr_ok) begin
         if (sel_per) period_q <= bus_wdata[CNT_W-1:0];
         if (sel_win) window_q <= bus_wdata[CNT_W-1:0];
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (rd_ok) begin
         if (sel_ctrl) begin
            bus_rdata[MASK_LSB +: NMST] = mask_q;
            bus_rdata[4:0] = {cfg_q.hlock, cfg_q.slock, cfg_q.win, cfg_q.irq_first, cfg_q.run};
         end
         if (sel_flag) bus_rdata[0] = flag_i;
         if (sel_per)  bus_rdata[CNT_W-1:0] = period_q;
         if (sel_win)  bus_rdata[CNT_W-1:0] = window_q;
         if (sel_cnt)  bus_rdata[CNT_W-1:0] = cnt_i;
      end
   end

   assign cfg_o    = cfg_q;
   assign period_o = period_q;
   assign window_o = window_q;

   AST_HLOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_q.hlock |=> cfg_q.hlock); // R10
   AST_LOCK_FREEZES_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q.slock || cfg_q.hlock) |=> $stable(period_q) && $stable(window_q)); // R8
   AST_DENIED_NO_KEY: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !mask_q[bus_master]) |=> $stable(key_q) && $stable(cfg_q)); // R11

endmodule

// File: rtl/winwdt_core.sv
module winwdt_core #(
   parameter int unsigned CNT_W  = 32,
   parameter logic [31:0] TO_RST = 32'h0000_FFFF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             run,
   input  logic             irq_first,
   input  logic             win,
   input  logic [CNT_W-1:0] period,
   input  logic [CNT_W-1:0] window,
   input  logic             svc,
   input  logic             flag_clr,
   output logic [CNT_W-1:0] cnt_o,
   output logic             flag_o,
   output logic             rst_o
);

   if (CNT_W < 8 || CNT_W > 32) begin : g_chk_cnt
      $error("winwdt_core: CNT_W out of range");
   end

   logic [CNT_W-1:0] cnt_q;
   logic flag_q, rst_q, expire, early;

   assign expire = run & ~svc & tick & (cnt_q == '0);
   assign early  = run & svc & win & (cnt_q >= window);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt_q <= TO_RST[CNT_W-1:0];
      else if (!run)      cnt_q <= period;
      else if (svc)       cnt_q <= period;
      else if (tick)      cnt_q <= (cnt_q == '0) ? period : cnt_q - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              flag_q <= 1'b0;
      else if (expire && !flag_q && irq_first) flag_q <= 1'b1;
      else if (flag_clr)                       flag_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                       rst_q <= 1'b0;
      else if ((expire && (flag_q || !irq_first)) || early) rst_q <= 1'b1;
   end

   assign cnt_o  = cnt_q;
   assign flag_o = flag_q;
   assign rst_o  = rst_q;

   AST_RST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      rst_q |=> rst_q); // R13
   AST_SECOND_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && !svc && cnt_q == '0 && flag_q) |=> rst_q); // R5
   AST_EARLY_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
      (run && svc && win && cnt_q >= window) |=> rst_q); // R7
   AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !svc && !tick) |=> $stable(cnt_q)); // R2
   AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !svc && tick && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1); // R2

endmodule

// File: rtl/winwdt.sv
module winwdt
   import winwdt_pkg::*;
#(
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned CNT_W     = 32,
   parameter int unsigned MST_W     = 3,
   parameter logic [31:0] TO_RST    = 32'h0000_FFFF,
   parameter logic [31:0] WIN_RST   = 32'h0,
   parameter bit          RUN_RST   = 1'b0,
   parameter int unsigned TICK_MODE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              osc_tick,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   input  logic [MST_W-1:0]  bus_master,
   output logic [31:0]       bus_rdata,
   output logic              bus_err,
   output logic              wdt_irq,
   output logic              wdt_rst_req
);

   wdt_cfg_t         cfg;
   logic [CNT_W-1:0] period, window, cnt;
   logic             tick, svc, flag_clr, flag;

   winwdt_tick #(.TICK_MODE(TICK_MODE)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick_in(osc_tick), .tick_o(tick)
   );

   winwdt_regs #(
      .ADDR_W(ADDR_W), .CNT_W(CNT_W), .MST_W(MST_W),
      .TO_RST(TO_RST), .WIN_RST(WIN_RST), .RUN_RST(RUN_RST)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_master(bus_master),
      .cnt_i(cnt), .flag_i(flag),
      .cfg_o(cfg), .period_o(period), .window_o(window),
      .svc_o(svc), .flag_clr_o(flag_clr),
      .bus_err(bus_err), .bus_rdata(bus_rdata)
   );

   winwdt_core #(.CNT_W(CNT_W), .TO_RST(TO_RST)) u_core (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .run(cfg.run), .irq_first(cfg.irq_first), .win(cfg.win),
      .period(period), .window(window), .svc(svc), .flag_clr(flag_clr),
      .cnt_o(cnt), .flag_o(flag), .rst_o(wdt_rst_req)
   );

   assign wdt_irq = flag;

endmodule

// File: tb/winwdt_bench.sv
`timescale 1ns/1ps
module winwdt_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        osc_tick = 1'b0;
   logic        bus_valid = 1'b0;
   logic        bus_write = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [2:0]  bus_master = '0;
   logic [31:0] bus_rdata;
   logic        bus_err, wdt_irq, wdt_rst_req;

   always #2.5 clk = ~clk;

   winwdt u_winwdt (
      .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick),
      .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_master(bus_master),
      .bus_rdata(bus_rdata), .bus_err(bus_err),
      .wdt_irq(wdt_irq), .wdt_rst_req(wdt_rst_req)
   );

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   // behavioural model state
   bit m_run, m_irqf, m_win, m_sl, m_hl, m_flag, m_rst, m_tk_d;
   logic [7:0]  m_mask;
   logic [31:0] m_per, m_wv, m_cnt;
   int m_key;

   task automatic model_reset();
      m_run = 0; m_irqf = 0; m_win = 0; m_sl = 0; m_hl = 0;
      m_flag = 0; m_rst = 0; m_tk_d = 0; m_mask = 8'hFF;
      m_per = 32'h0000_FFFF; m_wv = 0; m_cnt = 32'h0000_FFFF; m_key = 0;
   endtask

   task automatic check(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic step(input bit v, input bit w, input int a, input logic [31:0] d,
                       input int m, input bit tk, input string tag);
      bit e, svc, clr, setf;
      logic [31:0] rd;
      @(negedge clk);
      bus_valid = v; bus_write = w; bus_addr = 4'(a); bus_wdata = d;
      bus_master = 3'(m); osc_tick = tk;
      #1;
      e = v && (!m_mask[m] || a > 5 || (w && a == 5)
                || (w && (a == 0 || a == 2 || a == 3) && (m_sl || m_hl)));
      rd = 0;
      if (v && !w && !e) begin
         case (a)
            0: rd = {16'h0, m_mask, 3'b0, m_hl, m_sl, m_win, m_irqf, m_run};
            1: rd = {31'h0, m_flag};
            2: rd = m_per;
            3: rd = m_wv;
            5: rd = m_cnt;
            default: rd = 0;
         endcase
      end
      check(tag, "bus_err", {31'h0, bus_err}, {31'h0, e});
      check(tag, "bus_rdata", bus_rdata, rd);
      check(tag, "wdt_irq", {31'h0, wdt_irq}, {31'h0, m_flag});
      check(tag, "wdt_rst_req", {31'h0, wdt_rst_req}, {31'h0, m_rst});
      // next state
      svc = 0; clr = 0; setf = 0;
      if (v && w && !e) begin
         case (a)
            0: begin
               m_run = d[0]; m_irqf = d[1]; m_win = d[2]; m_sl = d[3]; m_hl = d[4];
               m_mask = d[15:8];
            end
            1: clr = d[0];
            2: m_per = d;
            3: m_wv = d;
            4: begin
               if (m_key == 1 && d == 32'hB480) svc = 1;
               if (m_key == 2 && d == 32'hD928 && !m_hl) m_sl = 0;
               if (d == 32'hA602) m_key = 1;
               else if (d == 32'hC520) m_key = 2;
               else m_key = 0;
            end
            default: ;
         endcase
      end
      if (!m_run) m_cnt = m_per;
      else if (svc) begin
         if (m_win && m_cnt >= m_wv) m_rst = 1;
         m_cnt = m_per;
      end else if (m_tk_d) begin
         if (m_cnt == 0) begin
            if (m_flag || !m_irqf) m_rst = 1;
            else setf = 1;
            m_cnt = m_per;
         end else m_cnt = m_cnt - 1;
      end
      m_flag = setf || (m_flag && !clr);
      m_tk_d = tk;
   endtask

   task automatic wr(input int a, input logic [31:0] d, input string tag);
      step(1, 1, a, d, 0, 0, tag);
   endtask
   task automatic rdr(input int a, input string tag);
      step(1, 0, a, 0, 0, 0, tag);
   endtask
   task automatic ticks(input int n, input string tag);
      for (int i = 0; i < n; i++) step(1, 0, 5, 0, 0, 1, tag);
   endtask
   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, tag);
   endtask
   task automatic do_reset();
      @(negedge clk);
      rst_n = 0; bus_valid = 0; osc_tick = 0;
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog run hung actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      do_reset();
      // R1 reset state
      rdr(0, "R1"); rdr(2, "R1"); rdr(5, "R1"); rdr(1, "R1");
      // R2, R4, R6 counting and first expiry with interrupt
      wr(2, 4, "R2");
      wr(0, 32'hFF03, "R4");
      ticks(7, "R2");
      idle(3, "R2");
      rdr(5, "R2");
      rdr(1, "R4");
      wr(1, 1, "R6");
      ticks(7, "R6");
      rdr(1, "R6");
      wr(1, 1, "R6");
      // R3 service and broken pair
      ticks(2, "R3");
      wr(4, 32'hA602, "R3"); wr(4, 32'hB480, "R3");
      rdr(5, "R3");
      ticks(2, "R3");
      wr(4, 32'hA602, "R3"); wr(4, 32'h1234, "R3"); wr(4, 32'hB480, "R3");
      rdr(5, "R3");
      // R5, R13 second expiry with flag pending
      ticks(12, "R5");
      idle(4, "R13");
      rdr(5, "R13");

      do_reset();
      wr(2, 2, "R4"); wr(0, 32'hFF01, "R4");
      ticks(5, "R4");
      idle(2, "R13");

      // R7 window: early service
      do_reset();
      wr(2, 8, "R7"); wr(3, 4, "R7"); wr(0, 32'hFF07, "R7");
      wr(4, 32'hA602, "R7"); wr(4, 32'hB480, "R7");
      idle(3, "R7");
      // R7 window: legal service
      do_reset();
      wr(2, 8, "R7"); wr(3, 4, "R7"); wr(0, 32'hFF07, "R7");
      ticks(7, "R7");
      wr(4, 32'hA602, "R7"); wr(4, 32'hB480, "R7");
      rdr(5, "R7"); idle(2, "R7");

      // R8, R9 soft lock
      do_reset();
      wr(0, 32'hFF08, "R8");
      wr(2, 32'h55, "R8"); wr(3, 32'h66, "R8"); wr(0, 32'hFF00, "R8");
      rdr(2, "R8"); rdr(0, "R8");
      wr(4, 32'hC520, "R9"); wr(4, 32'h5555, "R9"); wr(4, 32'hD928, "R9");
      wr(2, 32'h77, "R9");
      wr(4, 32'hC520, "R9"); wr(4, 32'hD928, "R9");
      wr(2, 32'h77, "R9"); rdr(2, "R9"); rdr(0, "R9");
      // R10 hard lock
      wr(0, 32'hFF10, "R10");
      wr(2, 32'h99, "R10");
      wr(4, 32'hC520, "R10"); wr(4, 32'hD928, "R10");
      wr(3, 32'h99, "R10"); wr(0, 32'hFF00, "R10");
      rdr(0, "R10"); rdr(2, "R10");

      // R11 master permissions
      do_reset();
      wr(0, 32'h0500, "R11");
      step(1, 0, 0, 0, 1, 0, "R11");
      step(1, 1, 2, 32'h33, 3, 0, "R11");
      step(1, 1, 4, 32'hA602, 1, 0, "R11");
      step(1, 1, 4, 32'hB480, 0, 0, "R11");
      rdr(2, "R11");
      step(1, 1, 2, 32'h44, 2, 0, "R11");
      step(1, 0, 2, 0, 2, 0, "R11");
      // R12 unmapped and read-only
      rdr(7, "R12"); rdr(6, "R12"); wr(5, 32'h1, "R12"); wr(15, 32'h1, "R12");
      rdr(5, "R12");

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule